// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block derives the bit timing of a serial port from the system clock. A 12-bit divisor drives a down-counter that reloads itself whenever it reaches zero. Each time the counter reaches zero, the block emits a base tick, so the base tick rate is the system clock rate divided by (divisor + 1). The base tick goes to the receiver's sampling logic without further division.

For the transmitter, a prescaler divides the base tick further. The ratio is 16 in normal asynchronous mode, 8 in asynchronous double-speed mode and 2 in synchronous master mode. In synchronous master mode the block also drives a square-wave serial clock.

Every output is a one-cycle enable, or a level, in the system clock domain. No derived clocks are produced. Software loads the divisor in two parts: the upper four bits are staged first, and the divisor takes the full value when the low byte is written.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low, `rx_tick`, `tx_tick` and `xck_out` are all low. After release, the divisor and both counters start from zero, so `rx_tick` is high on every cycle until the divisor is written.
- R2: With divisor value D, `rx_tick` is a single-cycle pulse that repeats every D+1 clock cycles, and it is never high in two consecutive cycles when D ≥ 1.
- R3: A low-byte write reloads the counter at once, wherever it is in its count. `rx_tick` is low in the cycle of the write, and the first tick after it comes exactly D+1 cycles after the write cycle.
- R4: A high-part write alone leaves the active divisor and the tick period unchanged. The staged bits become the divisor's upper four bits at the next low-byte write. If the high and low parts are written in the same cycle, the new high bits are used.
- R5: With `sync_mode`=0 and `dbl_speed`=0, `tx_tick` marks every 16th `rx_tick`.
- R6: With `sync_mode`=0 and `dbl_speed`=1, `tx_tick` marks every 8th `rx_tick`.
- R7: With `sync_mode`=1, `tx_tick` marks every 2nd `rx_tick`, whatever the value of `dbl_speed`.
- R8: `tx_tick` is high only in cycles where `rx_tick` is high.
- R9: With `sync_mode`=1, `xck_out` is low for the first D+1-cycle interval after a low-byte write and then toggles every D+1 cycles. It falls right after each `tx_tick`. With `sync_mode`=0, `xck_out` is held low.
- R10: A low-byte write also clears the transmit prescaler. The first `tx_tick` after the write therefore falls on the N-th `rx_tick`, where N is the mode ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| div_hi_we | input | 1 | Stage the upper divisor bits |
| div_hi_data | input | 4 | Upper divisor bits [11:8] |
| div_lo_we | input | 1 | Write the low byte, commit the divisor and reload the counter |
| div_lo_data | input | 8 | Lower divisor bits [7:0] |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| dbl_speed | input | 1 | 1 = double speed; used only when `sync_mode`=0 |
| rx_tick | output | 1 | Base tick enable for the receiver |
| tx_tick | output | 1 | Transmit bit enable |
| xck_out | output | 1 | Serial clock level for synchronous master mode |

## Verification
Two functions can meet in one cycle: a low-byte reload and the moment the counter reaches zero, which would otherwise issue a tick and advance the prescaler. The bench provokes this with writes at D=0, where the counter sits at zero in every cycle, and with a write in the middle of a long count. It judges the outcome by checking that no tick appears in the write cycle and that every following `rx_tick`, `tx_tick` and `xck_out` value lines up with a cycle grid counted from the write. A high-part write that lands between two ticks is also checked: it must leave the tick spacing unchanged.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned RATIO_NORM = 16;
  localparam int unsigned RATIO_DBL  = 8;
  localparam int unsigned RATIO_SYNC = 2;
  localparam int unsigned PRE_W      = $clog2(RATIO_NORM);

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_DBL  = 2'd1,
    MODE_SYNC = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic sync_i, input logic dbl_i);
    if (sync_i)     return MODE_SYNC;
    else if (dbl_i) return MODE_DBL;
    else            return MODE_NORM;
  endfunction

  function automatic logic [PRE_W-1:0] last_count(input xfer_mode_e m);
    case (m)
      MODE_SYNC: return PRE_W'(RATIO_SYNC - 1);
      MODE_DBL:  return PRE_W'(RATIO_DBL - 1);
      default:   return PRE_W'(RATIO_NORM - 1);
    endcase
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_int_n = sh_q[STAGES-1];

endmodule

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned HI_W = DIV_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic [HI_W-1:0]  hi_data,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  lo_data,
  output logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] div_wr
);

  logic [HI_W-1:0]  hi_buf_q, hi_buf_d, hi_eff;
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    hi_eff   = hi_we ? hi_data : hi_buf_q;
    div_wr   = {hi_eff, lo_data};
    hi_buf_d = hi_eff;
    div_d    = lo_we ? div_wr : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_buf_q <= '0;
      div_q    <= '0;
    end else begin
      hi_buf_q <= hi_buf_d;
      div_q    <= div_d;
    end
  end

  assign divisor = div_q;

endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [DIV_W-1:0] reload_val,
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] cnt,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    if (reload)       cnt_d = reload_val;
    else if (at_zero) cnt_d = divisor;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & ~reload & at_zero;
  assign cnt  = cnt_q;

endmodule

// File: rtl/baud_tx_div.sv
module baud_tx_div
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       restart,
  input  xfer_mode_e mode,
  output logic       tx_tick,
  output logic       xck
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             wrap;

  always_comb begin
    wrap = (pre_q >= last_count(mode));
    if (restart)        pre_d = '0;
    else if (base_tick) pre_d = wrap ? '0 : pre_q + 1'b1;
    else                pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tx_tick = base_tick & wrap;
  assign xck     = (mode == MODE_SYNC) & pre_q[0];

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned HI_W = DIV_W - LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            div_hi_we,
  input  logic [HI_W-1:0] div_hi_data,
  input  logic            div_lo_we,
  input  logic [LO_W-1:0] div_lo_data,
  input  logic            sync_mode,
  input  logic            dbl_speed,
  output logic            rx_tick,
  output logic            tx_tick,
  output logic            xck_out
);

  logic             rst_int_n;
  logic [DIV_W-1:0] divisor, div_wr, cnt;
  logic             base_tick;
  xfer_mode_e       mode;

  assign mode = decode_mode(sync_mode, dbl_speed);

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  baud_div_reg #(.DIV_W(DIV_W), .LO_W(LO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hi_we   (div_hi_we),
    .hi_data (div_hi_data),
    .lo_we   (div_lo_we),
    .lo_data (div_lo_data),
    .divisor (divisor),
    .div_wr  (div_wr)
  );

  baud_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (rst_int_n),
    .reload     (div_lo_we),
    .reload_val (div_wr),
    .divisor    (divisor),
    .cnt        (cnt),
    .tick       (base_tick)
  );

  baud_tx_div u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .base_tick (base_tick),
    .restart   (div_lo_we),
    .mode      (mode),
    .tx_tick   (tx_tick),
    .xck       (xck_out)
  );

  assign rx_tick = base_tick;

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_hi_we,
  input logic             div_lo_we,
  input logic             sync_mode,
  input logic             rx_tick,
  input logic             tx_tick,
  input logic             xck_out,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] cnt
);

  // R8: transmit enable only together with a base tick
  a_r8_tx_within_rx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> rx_tick);

  // R3: no tick in the cycle of a low-byte write
  a_r3_no_tick_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    div_lo_we |-> !rx_tick);

  // R2: after a tick the counter restarts from the active divisor
  a_r2_reload_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> (cnt == $past(divisor)));

  // R4: staging the high part alone keeps the divisor
  a_r4_hi_alone_keeps_div: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hi_we && !div_lo_we) |=> $stable(divisor));

  // R9: serial clock held low in asynchronous mode
  a_r9_xck_low_async: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !xck_out);

  // R9: serial clock falls after each transmit enable in synchronous mode
  a_r9_xck_falls_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && tx_tick) |=> !xck_out);

endmodule

bind uart_baud_gen baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_hi_we (div_hi_we),
  .div_lo_we (div_lo_we),
  .sync_mode (sync_mode),
  .rx_tick   (rx_tick),
  .tx_tick   (tx_tick),
  .xck_out   (xck_out),
  .divisor   (divisor),
  .cnt       (cnt)
);

// File: tb/uart_baud_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_hi_we, div_lo_we, sync_mode, dbl_speed;
  logic [3:0] div_hi_data;
  logic [7:0] div_lo_data;
  logic       rx_tick, tx_tick, xck_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_baud_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_hi_we   (div_hi_we),
    .div_hi_data (div_hi_data),
    .div_lo_we   (div_lo_we),
    .div_lo_data (div_lo_data),
    .sync_mode   (sync_mode),
    .dbl_speed   (dbl_speed),
    .rx_tick     (rx_tick),
    .tx_tick     (tx_tick),
    .xck_out     (xck_out)
  );

  // {sync, dbl, divisor[11:0], expected ratio[4:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd0,    5'd16},
    {1'b0, 1'b1, 12'd0,    5'd8},
    {1'b1, 1'b0, 12'd0,    5'd2},
    {1'b0, 1'b0, 12'd1,    5'd16},
    {1'b0, 1'b1, 12'd1,    5'd8},
    {1'b1, 1'b1, 12'd1,    5'd2},
    {1'b1, 1'b0, 12'd2,    5'd2},
    {1'b1, 1'b1, 12'd4095, 5'd2},
    {1'b0, 1'b1, 12'd4095, 5'd8},
    {1'b0, 1'b0, 12'd4095, 5'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_div(input logic [11:0] d, input bit with_hi);
    @(negedge clk);
    div_hi_we   = with_hi;
    div_hi_data = d[11:8];
    div_lo_we   = 1'b1;
    div_lo_data = d[7:0];
  endtask

  // Write divisor, then compare every cycle against the expected grid.
  task automatic run_entry(input bit s, input bit dbl, input int d, input int n);
    int rx_err, tx_err, xk_err, first;
    string tag;
    rx_err = 0; tx_err = 0; xk_err = 0; first = -1;
    sync_mode = s;
    dbl_speed = dbl;
    write_div(12'(d), 1'b1);
    for (int c = 1; c <= n * (d + 1); c++) begin
      @(negedge clk);
      div_hi_we = 1'b0;
      div_lo_we = 1'b0;
      #1;
      if (rx_tick !== ((c % (d + 1)) == 0)) begin
        rx_err++;
        if (first < 0) first = c;
      end
      if (tx_tick !== (c == n * (d + 1))) tx_err++;
      if (xck_out !== (s && ((((c - 1) / (d + 1)) % 2) == 1))) xk_err++;
    end
    check(rx_err == 0, "R2/R3 rx grid mismatches", rx_err, 0);
    tag = (n == 16) ? "R5 R10 tx" : (n == 8) ? "R6 R10 tx" : "R7 R10 tx";
    check(tx_err == 0, tag, tx_err, 0);
    check(xk_err == 0, "R9 xck pattern", xk_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap, c0;
    rst_n = 1'b0;
    div_hi_we = 1'b0; div_lo_we = 1'b0;
    div_hi_data = '0; div_lo_data = '0;
    sync_mode = 1'b0; dbl_speed = 1'b0;

    // R1: quiet outputs during reset
    repeat (3) @(negedge clk);
    #1;
    check({rx_tick, tx_tick, xck_out} == 3'b000, "R1 outputs in reset",
          {rx_tick, tx_tick, xck_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(rx_tick === 1'b1, "R1 divisor zero after reset", rx_tick, 1);
    @(negedge clk);
    #1;
    check(rx_tick === 1'b1, "R1 tick every cycle", rx_tick, 1);

    // R2 R5 R6 R7 R9 R10: table walk
    for (int i = 0; i < NV; i++) begin
      run_entry(VEC[i][18], VEC[i][17], int'(VEC[i][16:5]), int'(VEC[i][4:0]));
    end

    // R3: reload in mid-count
    sync_mode = 1'b0; dbl_speed = 1'b0;
    write_div(12'd100, 1'b1);
    @(negedge clk);
    div_hi_we = 1'b0; div_lo_we = 1'b0;
    repeat (40) @(negedge clk);
    run_entry(1'b0, 1'b0, 5, 16);

    // R4: stage high part alone, period must stay 4
    sync_mode = 1'b1;
    run_entry(1'b1, 1'b0, 3, 2);
    @(negedge clk);
    div_hi_we = 1'b1; div_hi_data = 4'hA;
    @(negedge clk);
    div_hi_we = 1'b0;
    c0 = 0;
    for (int k = 0; k < 10 && c0 == 0; k++) begin
      #1;
      if (rx_tick) c0 = 1;
      else @(negedge clk);
    end
    gap = 0;
    for (int k = 1; k <= 20 && gap == 0; k++) begin
      @(negedge clk);
      #1;
      if (rx_tick) gap = k;
    end
    check(gap == 4, "R4 period kept after high-only write", gap, 4);

    // R4: low-only write commits staged high bits: 0xA07 -> first tick at 2568
    write_div(12'h007, 1'b0);
    gap = 0;
    for (int c = 1; c <= 3000 && gap == 0; c++) begin
      @(negedge clk);
      div_lo_we = 1'b0;
      #1;
      if (rx_tick) gap = c;
    end
    check(gap == 2568, "R4 staged high bits applied", gap, 2568);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule